// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Thresholds

This block is a first-in first-out store for 9-bit words whose write side and read side run on unrelated clocks. A producer pushes a word with a write strobe on its own clock. A consumer pops words in the same order on the other clock. Four active-low status outputs report the fill state. Two are fixed: nothing stored, and every slot taken. The other two are thresholds with adjustable offsets: near-empty and near-full.

The data path keeps plain strobe pins rather than a valid/ready pair. The full output is the back-pressure signal. A producer may hold its write strobe while full is low, but the block drops every such attempt, so it must wait for full to rise. The empty output plays the same role for the consumer. A read attempted while empty returns nothing new, and the output word holds its last value.

One pin has two roles, and its level during reset picks the role. If it is held high through reset, it is a second write enable. If it is held low through reset, it becomes a load strobe. While the load strobe is low, writes on the write clock set the two threshold offsets in turn, and reads on the read clock show those offsets on the output bus in the same turn.

Top module: `dcfifo_pflag`

## Requirements
- R1: After reset, empty_n = 0, aempty_n = 0, afull_n = 1 and full_n = 1. rd_data is 0, and both threshold offsets are 7.
- R2: Words leave on rd_data in the order they were written. Each word keeps all 9 bits, and rd_data shows the word from the read-clock edge that popped it onward.
- R3: A word is stored at a rising wr_clk edge when wr_en1_n = 0, wr_en2_ld = 1 and full_n = 1. In either mode, wr_en2_ld = 0 stops every FIFO write.
- R4: full_n is 0 exactly when DEPTH words are held. A write attempted while full_n = 0 is dropped, and the stored words are not changed.
- R5: A word is popped at a rising rd_clk edge only when rd_en1_n = 0, rd_en2_n = 0 and empty_n = 1. A read with only one enable low, or a read while empty, leaves rd_data and the stored words unchanged.
- R6: empty_n is 0 exactly when no word is held, and it changes only on rd_clk edges. After a write into an empty FIFO, it rises within four read-clock cycles.
- R7: aempty_n is 0 when the held word count is at or below the near-empty offset. It changes only on rd_clk edges.
- R8: afull_n is 0 when the free space is at or below the near-full offset. It changes only on wr_clk edges.
- R9: wr_en2_ld is sampled while rst_n is low and must be held over at least two edges of each clock. High selects dual-enable mode. Low selects load mode. The mode then stays fixed until the next reset.
- R10: In load mode, wr_en1_n = 0 with wr_en2_ld = 0 at a wr_clk edge stores wr_data into an offset register and leaves the FIFO contents unchanged. The first such write after reset goes to the near-empty offset, the next to the near-full offset, and the turn then wraps.
- R11: In load mode, both read enables low with wr_en2_ld = 0 at a rd_clk edge put an offset on rd_data and pop nothing. The offsets come in the turn near-empty, near-full, wrapping, with a turn pointer of their own that resets to near-empty.
- R12: Pointers cross between the clocks in Gray code through SYNC_STAGES flip-flops. Each pointer changes by at most one bit per edge. empty_n never rises in the first read-clock cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, shared by both sides |
| wr_en1_n | input | 1 | Active-low write strobe |
| wr_en2_ld | input | 1 | Second write enable, or offset load strobe (active low); role picked at reset |
| wr_data | input | 9 | Write word, or offset value in load access |
| rd_en1_n | input | 1 | Active-low read enable, first of two |
| rd_en2_n | input | 1 | Active-low read enable, second of two |
| rd_data | output | 9 | Popped word, or offset value in load access |
| empty_n | output | 1 | Low when no word is held (read clock) |
| aempty_n | output | 1 | Low at or below the near-empty threshold (read clock) |
| afull_n | output | 1 | Low at or below the near-full free-space threshold (write clock) |
| full_n | output | 1 | Low when every slot is taken (write clock) |

## Verification
The properties take three things for granted. First, wr_en2_ld is steady across every reset edge of both clocks, so the sampled mode holds. Second, the load strobe and the offset values change only while neither side is moving words. Third, inputs never move on an edge of their own clock. The bench drives every input on the falling edge of its own clock and holds the mode level for several edges of each clock during reset. It toggles wr_en2_ld or loads offsets only after waiting long enough for both pointers to pass through the synchronisers.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  typedef enum logic {SEL_AE = 1'b0, SEL_AF = 1'b1} ofs_sel_e;

  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             wclk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int WIDTH   = 9,
  parameter int DEPTH   = 64,
  parameter int OFS_W   = 9,
  parameter int DEF_OFS = 7,
  parameter int AW      = $clog2(DEPTH),
  parameter int PW      = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en1_n,
  input  logic             en2_ld,
  input  logic [WIDTH-1:0] din,
  input  logic [PW-1:0]    rgray_s,
  output logic [PW-1:0]    wgray,
  output logic [AW-1:0]    waddr,
  output logic             we,
  output logic             full_n,
  output logic             afull_n,
  output logic [OFS_W-1:0] ae_ofs,
  output logic [OFS_W-1:0] af_ofs,
  output logic             ld_mode
);
  localparam int CW = (PW > OFS_W) ? PW : OFS_W;

  logic [PW-1:0] wbin, wbin_nxt, rbin_s, used, free;
  logic          fifo_req, ofs_wr;
  ofs_sel_e      sel;

  always_comb begin
    fifo_req = !en1_n && en2_ld;
    we       = fifo_req && full_n;
    ofs_wr   = ld_mode && !en2_ld && !en1_n;
    wbin_nxt = wbin + PW'(we);
    rbin_s   = PW'(gray_to_bin(32'(rgray_s)));
    used     = wbin_nxt - rbin_s;
    free     = PW'(DEPTH) - used;
  end

  // mode is captured on every edge while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) ld_mode <= !en2_ld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin    <= '0;
      wgray   <= '0;
      full_n  <= 1'b1;
      afull_n <= 1'b1;
    end else begin
      wbin    <= wbin_nxt;
      wgray   <= PW'(bin_to_gray(32'(wbin_nxt)));
      full_n  <= (used != PW'(DEPTH));
      afull_n <= !(CW'(free) <= CW'(af_ofs));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ae_ofs <= OFS_W'(DEF_OFS);
      af_ofs <= OFS_W'(DEF_OFS);
      sel    <= SEL_AE;
    end else if (ofs_wr) begin
      if (sel == SEL_AE) ae_ofs <= OFS_W'(din);
      else               af_ofs <= OFS_W'(din);
      sel <= (sel == SEL_AE) ? SEL_AF : SEL_AE;
    end
  end

  assign waddr = wbin[AW-1:0];
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int WIDTH = 9,
  parameter int DEPTH = 64,
  parameter int OFS_W = 9,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en1_n,
  input  logic             en2_n,
  input  logic             ld_pin,
  input  logic [PW-1:0]    wgray_s,
  input  logic [OFS_W-1:0] ae_ofs,
  input  logic [OFS_W-1:0] af_ofs,
  input  logic [WIDTH-1:0] mem_q,
  output logic [PW-1:0]    rgray,
  output logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] dout,
  output logic             empty_n,
  output logic             aempty_n
);
  localparam int CW = (PW > OFS_W) ? PW : OFS_W;

  logic [PW-1:0] rbin, rbin_nxt, wbin_s, used;
  logic          rd_req, ofs_rd, re, ld_mode;
  ofs_sel_e      sel;

  always_comb begin
    rd_req   = !en1_n && !en2_n;
    ofs_rd   = ld_mode && !ld_pin && rd_req;
    re       = rd_req && empty_n && !ofs_rd;
    rbin_nxt = rbin + PW'(re);
    wbin_s   = PW'(gray_to_bin(32'(wgray_s)));
    used     = wbin_s - rbin_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ld_mode <= !ld_pin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      empty_n  <= 1'b0;
      aempty_n <= 1'b0;
    end else begin
      rbin     <= rbin_nxt;
      rgray    <= PW'(bin_to_gray(32'(rbin_nxt)));
      empty_n  <= (used != '0);
      aempty_n <= !(CW'(used) <= CW'(ae_ofs));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
      sel  <= SEL_AE;
    end else if (ofs_rd) begin
      dout <= (sel == SEL_AE) ? WIDTH'(ae_ofs) : WIDTH'(af_ofs);
      sel  <= (sel == SEL_AE) ? SEL_AF : SEL_AE;
    end else if (re) begin
      dout <= mem_q;
    end
  end

  assign raddr = rbin[AW-1:0];
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag #(
  parameter int WIDTH       = 9,
  parameter int DEPTH       = 64,
  parameter int SYNC_STAGES = 2,
  parameter int DEF_OFS     = 7
) (
  input  logic             wr_clk,
  input  logic             rd_clk,
  input  logic             rst_n,
  input  logic             wr_en1_n,
  input  logic             wr_en2_ld,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en1_n,
  input  logic             rd_en2_n,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty_n,
  output logic             aempty_n,
  output logic             afull_n,
  output logic             full_n
);
  localparam int AW    = $clog2(DEPTH);
  localparam int PW    = AW + 1;
  localparam int OFS_W = WIDTH;

  logic [PW-1:0]    wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0]    waddr, raddr;
  logic             we, ld_mode_w;
  logic [OFS_W-1:0] ae_ofs, af_ofs;
  logic [WIDTH-1:0] mem_q;

  dcf_wr_ctl #(.WIDTH(WIDTH), .DEPTH(DEPTH), .OFS_W(OFS_W), .DEF_OFS(DEF_OFS),
               .AW(AW), .PW(PW)) u_wr (
    .clk(wr_clk), .rst_n(rst_n), .en1_n(wr_en1_n), .en2_ld(wr_en2_ld),
    .din(wr_data), .rgray_s(rgray_s), .wgray(wgray), .waddr(waddr), .we(we),
    .full_n(full_n), .afull_n(afull_n), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
    .ld_mode(ld_mode_w)
  );

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
  );

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
  );

  dcf_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_q)
  );

  dcf_rd_ctl #(.WIDTH(WIDTH), .DEPTH(DEPTH), .OFS_W(OFS_W), .AW(AW), .PW(PW)) u_rd (
    .clk(rd_clk), .rst_n(rst_n), .en1_n(rd_en1_n), .en2_n(rd_en2_n),
    .ld_pin(wr_en2_ld), .wgray_s(wgray_s), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
    .mem_q(mem_q), .rgray(rgray), .raddr(raddr), .dout(rd_data),
    .empty_n(empty_n), .aempty_n(aempty_n)
  );
endmodule

// File: rtl/dcf_chk.sv
module dcf_chk #(
  parameter int PW = 7
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst_n,
  input logic          wr_en2_ld,
  input logic          rd_en1_n,
  input logic          rd_en2_n,
  input logic          full_n,
  input logic          afull_n,
  input logic          empty_n,
  input logic          aempty_n,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rgray,
  input logic          ld_mode_w
);
  assert_no_overflow_R4: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |=> $stable(wgray));

  assert_wr_gated_R3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !wr_en2_ld |=> $stable(wgray));

  assert_no_underflow_R5: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |=> $stable(rgray));

  assert_rd_gated_R5: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_en1_n || rd_en2_n) |=> $stable(rgray));

  assert_afull_covers_full_R8: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |-> !afull_n);

  assert_aempty_covers_empty_R7: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);

  assert_wgray_step_R12: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  assert_rgray_step_R12: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);

  assert_mode_hold_R9: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $stable(ld_mode_w));
endmodule

bind dcfifo_pflag dcf_chk #(.PW(PW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en2_ld(wr_en2_ld),
  .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n), .full_n(full_n), .afull_n(afull_n),
  .empty_n(empty_n), .aempty_n(aempty_n), .wgray(wgray), .rgray(rgray),
  .ld_mode_w(ld_mode_w)
);

// File: tb/sim_dcfifo_pflag.sv
`timescale 1ns/1ps
module sim_dcfifo_pflag;
  localparam int DEPTH = 64;
  localparam int NV    = 10;
  // {writes[23:16], reads[15:8], pad[7:4], flags[3:0] = empty_n,aempty_n,afull_n,full_n}
  localparam logic [23:0] VEC [NV] = '{
    {8'd3,  8'd0,  4'd0, 4'b1011},
    {8'd5,  8'd0,  4'd0, 4'b1111},
    {8'd0,  8'd1,  4'd0, 4'b1011},
    {8'd50, 8'd0,  4'd0, 4'b1101},
    {8'd0,  8'd1,  4'd0, 4'b1111},
    {8'd8,  8'd0,  4'd0, 4'b1100},
    {8'd3,  8'd0,  4'd0, 4'b1100},
    {8'd0,  8'd64, 4'd0, 4'b0011},
    {8'd0,  8'd2,  4'd0, 4'b0011},
    {8'd1,  8'd1,  4'd0, 4'b0011}
  };

  logic wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic wr_en1_n = 1, wr_en2_ld = 1, rd_en1_n = 1, rd_en2_n = 1;
  logic [8:0] wr_data = '0;
  logic [8:0] rd_data;
  logic empty_n, aempty_n, afull_n, full_n;

  int nchk = 0, nfail = 0, seq = 0;
  bit done = 0;
  int q[$];
  logic [8:0] last, v;

  always #2.5 wr_clk = ~wr_clk;
  always #4   rd_clk = ~rd_clk;

  dcfifo_pflag #(.DEPTH(DEPTH)) u0 (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en1_n(wr_en1_n),
    .wr_en2_ld(wr_en2_ld), .wr_data(wr_data), .rd_en1_n(rd_en1_n),
    .rd_en2_n(rd_en2_n), .rd_data(rd_data), .empty_n(empty_n),
    .aempty_n(aempty_n), .afull_n(afull_n), .full_n(full_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_flags(input logic [3:0] exp, input string tag);
    logic [3:0] act;
    act = {empty_n, aempty_n, afull_n, full_n};
    check(act == exp, tag, int'(act), int'(exp));
  endtask

  task automatic settle();
    repeat (6) @(negedge rd_clk);
    repeat (6) @(negedge wr_clk);
  endtask

  task automatic do_reset(input logic mode_pin);
    rst_n = 0; wr_en2_ld = mode_pin; wr_en1_n = 1; rd_en1_n = 1; rd_en2_n = 1;
    repeat (4) @(negedge rd_clk);
    @(negedge wr_clk);
    rst_n = 1;
    q.delete();
    repeat (2) @(negedge wr_clk);
  endtask

  task automatic wr_word(input logic [8:0] d, input bit fifo);
    @(negedge wr_clk);
    wr_en1_n = 0; wr_data = d;
    @(negedge wr_clk);
    wr_en1_n = 1;
    if (fifo && q.size() < DEPTH) q.push_back(int'(d));
  endtask

  task automatic wr_seq(input int n);
    for (int k = 0; k < n; k++) begin
      wr_word(9'((seq * 37 + 5) & 9'h1FF), 1);
      seq++;
    end
  endtask

  task automatic rd_word(output logic [8:0] val);
    @(negedge rd_clk);
    rd_en1_n = 0; rd_en2_n = 0;
    @(negedge rd_clk);
    rd_en1_n = 1; rd_en2_n = 1;
    val = rd_data;
  endtask

  task automatic rd_check(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      rd_word(v);
      if (q.size() > 0) begin
        int e;
        e = q.pop_front();
        check(v == 9'(e), tag, int'(v), e);
      end else begin
        check(v == last, "R5 read while empty changed rd_data", int'(v), int'(last));
      end
      last = v;
    end
  endtask

  initial begin
    do_reset(1'b1);
    check_flags(4'b0011, "R1 reset flags (dual mode)");
    check(rd_data == 9'd0, "R1 reset rd_data", int'(rd_data), 0);
    last = '0;

    // vector table: R2 order, R4 full, R6 empty, R7/R8 default offsets of 7
    for (int i = 0; i < NV; i++) begin
      wr_seq(int'(VEC[i][23:16]));
      settle();
      rd_check(int'(VEC[i][15:8]), "R2 data order");
      settle();
      check_flags(VEC[i][3:0], $sformatf("R4/R6/R7/R8 flags after vector %0d", i));
    end

    // R3: second enable low blocks the write in dual mode
    wr_en2_ld = 0;
    wr_word(9'h155, 0);
    wr_en2_ld = 1;
    settle();
    check(empty_n == 1'b0, "R3 write with enable 2 low stored a word", int'(empty_n), 0);

    // R12 / R6: no early data indication, then rise within four read cycles
    wr_word(9'h0A5, 1);
    @(negedge rd_clk);
    check(empty_n == 1'b0, "R12 empty_n rose before sync latency", int'(empty_n), 0);
    repeat (3) @(negedge rd_clk);
    check(empty_n == 1'b1, "R6 empty_n late after write", int'(empty_n), 1);

    // R5: one read enable alone pops nothing
    @(negedge rd_clk); rd_en1_n = 0;
    @(negedge rd_clk); rd_en1_n = 1;
    check(rd_data == last, "R5 single enable changed rd_data", int'(rd_data), int'(last));
    @(negedge rd_clk); rd_en2_n = 0;
    @(negedge rd_clk); rd_en2_n = 1;
    settle();
    check(empty_n == 1'b1, "R5 single enable popped a word", int'(empty_n), 1);
    rd_check(1, "R2 word after single-enable attempts");
    settle();
    check_flags(4'b0011, "R6 empty after draining");

    // load mode
    do_reset(1'b0);
    check_flags(4'b0011, "R1 reset flags (load mode)");
    rd_word(v); check(v == 9'd7, "R1/R11 default near-empty offset", int'(v), 7);
    rd_word(v); check(v == 9'd7, "R1/R11 default near-full offset", int'(v), 7);
    wr_word(9'd3, 0);
    wr_word(9'd10, 0);
    settle();
    check(empty_n == 1'b0, "R10 offset write reached FIFO", int'(empty_n), 0);
    rd_word(v); check(v == 9'd3,  "R11 near-empty offset readback", int'(v), 3);
    rd_word(v); check(v == 9'd10, "R11 near-full offset readback", int'(v), 10);
    rd_word(v); check(v == 9'd3,  "R11 offset turn wraps", int'(v), 3);

    wr_en2_ld = 1;
    settle();
    wr_seq(3);  settle();
    check_flags(4'b1011, "R7 count 3 at offset 3 (R9 single-enable write)");
    wr_seq(1);  settle();
    check_flags(4'b1111, "R7 count 4 above offset 3");
    wr_seq(49); settle();
    check_flags(4'b1111, "R8 free 11 above offset 10");
    wr_seq(1);  settle();
    check_flags(4'b1101, "R8 free 10 at offset 10");
    last = rd_data;
    rd_check(54, "R2 data order in load mode");
    settle();
    check_flags(4'b0011, "R6 empty after load-mode drain");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule